// File: doc/BRIEF.md
# Banked Extended-Register UART Decoder

This block is the register-access front end of a 16550-style serial port that carries a hidden set of extended registers. A host reaches it over a byte-wide bus with a 3-bit offset, a write strobe and a read strobe. The standard offsets are plain storage, and offset 3 is the line control byte. The serializers, the baud divider and the FIFOs sit elsewhere.

Writing the unlock value 0xBF to the line control byte changes what some offsets mean. Offset 2 then reaches an 8-bit feature register in place of the standard offset-2 byte. Offsets 4 to 7 reach four slots of the bank chosen by feature bits 7:6. Bank 0 holds the four flow-control characters. Bank 1 holds the receive and transmit thresholds. Bank 2 holds an enumeration byte, a read-only identity byte and two control bytes. Bank 3 is empty.

Writing any other value to the line control byte locks access again and restores the standard meanings. Both the extended contents and the standard contents survive every change of mode.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset every standard byte, the feature register and all bank slots read 0x00, so the block starts locked (line control 0x00).
- R2: While locked, a write to offset N (0 to 7) stores the byte, and a later read of offset N returns it.
- R3: A write of 0xBF to offset 3 unlocks the block from the next cycle. While unlocked, offset 2 reads and writes the feature register, and the standard offset-2 byte is left untouched.
- R4: While unlocked, offsets 4, 5, 6 and 7 address slots 0, 1, 2 and 3 of the bank selected by feature bits 7:6 (00 is bank 0, 01 bank 1, 10 bank 2, 11 bank 3).
- R5: Bank slots, the feature register and the standard bytes at offsets 4 to 7 are separate storage. A write to one changes none of the others.
- R6: In bank 2, offset 5 always reads the parameter HW_ID (default 0x5A), and writes to it are ignored.
- R7: While bank 3 is selected, writes to offsets 4 to 7 are dropped and reads of them return 0x00.
- R8: The feature register keeps all 8 bits. A read-modify-write that sets or clears bit 4 (the enhanced-mode enable) leaves the other bits as they were.
- R9: A write to offset 3 of any value other than 0xBF locks the block from the next cycle. Offsets 2 and 4 to 7 then return to their standard bytes, and the extended contents are kept.
- R10: A read strobe in cycle n places the addressed byte on the read data port at the edge ending cycle n. The port holds that value in every cycle without a read strobe.
- R11: Offsets 0, 1 and 3 stay standard storage whether the block is locked or unlocked. Offset 3 reads 0xBF while the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
On every cycle, the assertions check three things. The read port holds its value between read strobes. The unlock state follows every write to the line control byte. Reads of bank 3 return zero, and reads of the identity slot return the parameter. Only the bench scenarios can show that stored bytes survive mode changes and come back from the right bank. They also show that the standard and extended bytes at a shared offset never overwrite each other, and that a read-modify-write of the enable bit keeps the rest of the feature register. These scenarios compare every read against a model of all the storage.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  // where an access lands after the mode-dependent remap
  typedef enum logic [1:0] {
    TGT_STD  = 2'd0,
    TGT_FEAT = 2'd1,
    TGT_BANK = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  localparam int LCR_OFFSET  = 3;
  localparam int FEAT_OFFSET = 2;
endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_bank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BANK_W = 2,
  parameter int SLOT_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              unlocked,
  input  logic [BANK_W-1:0] bank,
  output tgt_e              tgt,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [BANK_W-1:0] EMPTY_BANK = {BANK_W{1'b1}};

  assign slot = addr[SLOT_W-1:0];

  always_comb begin
    tgt = TGT_STD;
    if (unlocked) begin
      if (addr == ADDR_W'(FEAT_OFFSET)) begin
        tgt = TGT_FEAT;
      end else if (addr[ADDR_W-1]) begin
        tgt = (bank == EMPTY_BANK) ? TGT_NONE : TGT_BANK;
      end
    end
  end
endmodule

// File: rtl/uart_std_regs.sv
module uart_std_regs
  import uart_bank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] lcr
);
  localparam int NUM_OFFS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [NUM_OFFS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_OFFS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
  assign lcr   = mem[LCR_OFFSET];
endmodule

// File: rtl/uart_ext_banks.sv
module uart_ext_banks #(
  parameter int          DATA_W       = 8,
  parameter int          BANK_W       = 2,
  parameter int          SLOT_W       = 2,
  parameter int          STORED_BANKS = 3,
  parameter int          ID_BANK      = 2,
  parameter int          ID_SLOT      = 1,
  parameter logic [7:0]  HW_ID        = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] bank,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int SLOTS     = 1 << SLOT_W;

  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    if (b < STORED_BANKS) begin : g_store
      logic [DATA_W-1:0] cells [SLOTS];
      logic              hit;
      assign hit = wr_en && (bank == BANK_W'(b)) &&
                   !((b == ID_BANK) && (slot == SLOT_W'(ID_SLOT)));
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < SLOTS; s++) cells[s] <= '0;
        end else if (hit) begin
          cells[slot] <= wdata;
        end
      end
      if (b == ID_BANK) begin : g_id
        assign bank_rd[b] = (slot == SLOT_W'(ID_SLOT)) ? DATA_W'(HW_ID) : cells[slot];
      end else begin : g_plain
        assign bank_rd[b] = cells[slot];
      end
    end else begin : g_empty
      assign bank_rd[b] = '0;
    end
  end

  assign rdata = bank_rd[bank];
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int         ADDR_W       = 3,
  parameter int         DATA_W       = 8,
  parameter int         BANK_W       = 2,
  parameter int         STORED_BANKS = 3,
  parameter logic [7:0] UNLOCK_VAL   = 8'hBF,
  parameter logic [7:0] HW_ID        = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int SLOT_W = ADDR_W - 1;

  tgt_e              tgt;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] lcr;
  logic [DATA_W-1:0] std_rd;
  logic [DATA_W-1:0] ext_rd;
  logic [DATA_W-1:0] feat_q;
  logic              unlocked;
  logic [BANK_W-1:0] bank_sel;

  assign unlocked = (lcr == DATA_W'(UNLOCK_VAL));
  assign bank_sel = feat_q[DATA_W-1 -: BANK_W];

  uart_bank_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SLOT_W(SLOT_W)) i_decode (
    .addr(bus_addr), .unlocked(unlocked), .bank(bank_sel), .tgt(tgt), .slot(slot)
  );

  uart_std_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_std (
    .clk(clk), .rst(rst), .wr_en(bus_wr && (tgt == TGT_STD)),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(std_rd), .lcr(lcr)
  );

  uart_ext_banks #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .SLOT_W(SLOT_W),
    .STORED_BANKS(STORED_BANKS), .HW_ID(HW_ID)
  ) i_ext (
    .clk(clk), .rst(rst), .wr_en(bus_wr && (tgt == TGT_BANK)),
    .bank(bank_sel), .slot(slot), .wdata(bus_wdata), .rdata(ext_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      feat_q <= '0;
    end else if (bus_wr && (tgt == TGT_FEAT)) begin
      feat_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (tgt)
        TGT_STD:  bus_rdata <= std_rd;
        TGT_FEAT: bus_rdata <= feat_q;
        TGT_BANK: bus_rdata <= ext_rd;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk #(
  parameter int         ADDR_W     = 3,
  parameter int         DATA_W     = 8,
  parameter int         BANK_W     = 2,
  parameter logic [7:0] UNLOCK_VAL = 8'hBF,
  parameter logic [7:0] HW_ID      = 8'h5A
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              unlocked,
  input logic [BANK_W-1:0] bank_sel
);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  a_r3_unlock: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd3 && bus_wdata == DATA_W'(UNLOCK_VAL)) |=> unlocked);

  a_r9_relock: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd3 && bus_wdata != DATA_W'(UNLOCK_VAL)) |=> !unlocked);

  a_r7_bank3_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unlocked && bus_addr[2] && bank_sel == 2'd3) |=> (bus_rdata == '0));

  a_r6_hw_id: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unlocked && bus_addr == 3'd5 && bank_sel == 2'd2) |=> (bus_rdata == DATA_W'(HW_ID)));
endmodule

bind uart_bank_regs uart_bank_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
  .UNLOCK_VAL(UNLOCK_VAL), .HW_ID(HW_ID)
) i_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlocked(unlocked), .bank_sel(bank_sel)
);

// File: tb/test_uart_bank_regs.sv
module test_uart_bank_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  bit [7:0] m_std [8];
  bit [7:0] m_feat;
  bit [7:0] m_bank [3][4];

  localparam bit [7:0] ID_VAL = 8'h5A;

  always #2 clk = ~clk;

  uart_bank_regs i_uart_bank_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic bit m_unlocked();
    return m_std[3] == 8'hBF;
  endfunction

  function automatic bit [7:0] m_read(bit [2:0] a);
    if (m_unlocked() && a == 3'd2) return m_feat;
    if (m_unlocked() && a[2]) begin
      case (m_feat[7:6])
        2'd3: return 8'h00;
        2'd2: return (a[1:0] == 2'd1) ? ID_VAL : m_bank[2][a[1:0]];
        default: return m_bank[m_feat[7:6]][a[1:0]];
      endcase
    end
    return m_std[a];
  endfunction

  function automatic void m_write(bit [2:0] a, bit [7:0] d);
    if (m_unlocked() && a == 3'd2) m_feat = d;
    else if (m_unlocked() && a[2]) begin
      if (m_feat[7:6] != 2'd3 && !(m_feat[7:6] == 2'd2 && a[1:0] == 2'd1))
        m_bank[m_feat[7:6]][a[1:0]] = d;
    end else m_std[a] = d;
  endfunction

  task automatic check(string req, bit [7:0] act, bit [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(bit [2:0] a, bit [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd(bit [2:0] a, string req);
    bit [7:0] exp;
    exp = m_read(a);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [7:0] v;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R1: everything zero, locked
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");

    // R2: plain storage while locked
    for (int a = 0; a < 8; a++) wr(3'(a), 8'(8'h10 + a));
    for (int a = 0; a < 8; a++) rd(3'(a), "R2");

    // R3: unlock; offset 2 becomes feature register
    wr(3'd3, 8'hBF);
    rd(3'd2, "R3");
    wr(3'd2, 8'h05);
    rd(3'd2, "R3");
    // R11: offsets 0,1,3 remain standard
    rd(3'd0, "R11"); rd(3'd1, "R11"); rd(3'd3, "R11");
    wr(3'd1, 8'h77); rd(3'd1, "R11");

    // R4 / R5: fill banks 0,1,2 and read back
    for (int b = 0; b < 3; b++) begin
      wr(3'd2, 8'(b << 6));
      for (int s = 0; s < 4; s++) wr(3'(4 + s), 8'(8'hA0 + b * 16 + s));
    end
    for (int b = 0; b < 3; b++) begin
      wr(3'd2, 8'(b << 6));
      for (int s = 0; s < 4; s++) rd(3'(4 + s), "R4");
    end
    // R6: identity slot ignores writes
    wr(3'd2, 8'h80);
    wr(3'd5, 8'hEE);
    rd(3'd5, "R6");
    // R7: bank 3 drops writes, reads zero
    wr(3'd2, 8'hC0);
    wr(3'd4, 8'h99); wr(3'd7, 8'h98);
    rd(3'd4, "R7"); rd(3'd7, "R7");
    wr(3'd2, 8'h00);
    rd(3'd4, "R7"); rd(3'd7, "R7");

    // R8: read-modify-write of bit 4
    wr(3'd2, 8'h4B);
    rd(3'd2, "R8");
    wr(3'd2, 8'h4B | 8'h10); rd(3'd2, "R8");
    wr(3'd2, 8'h5B & ~8'h10); rd(3'd2, "R8");

    // R9: relock, standard bytes back, extended kept
    wr(3'd3, 8'h03);
    for (int a = 2; a < 8; a++) rd(3'(a), "R9");
    wr(3'd3, 8'hBF);
    for (int a = 4; a < 8; a++) rd(3'(a), "R5");
    wr(3'd3, 8'h00);

    // R10: data held without read strobe
    rd(3'd6, "R10");
    v = bus_rdata;
    for (int i = 0; i < 4; i++) begin
      bus_addr = 3'(i);
      @(posedge clk); @(negedge clk);
      check("R10", bus_rdata, v);
    end

    // random mix against model (R2 R4 R5)
    for (int i = 0; i < 600; i++) begin
      bit [2:0] a;
      bit [7:0] d;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (a == 3'd3 && $urandom_range(0, 1) == 1) d = 8'hBF;
      if ($urandom_range(0, 1) == 1) wr(a, d);
      else rd(a, "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule